// File: doc/BRIEF.md
# FIFO-Buffered Asynchronous Serial Transmitter with Selectable Bit Clock

This block turns bytes written into a sixteen-entry queue into asynchronous serial frames on a single output line. Each frame has a low start bit, eight data bits sent least significant bit first, and a high stop bit. Every bit lasts sixteen ticks of an oversampling clock. Queued bytes go out back to back with no idle gap between frames.

The oversampling tick comes from one of two sources. The first is an internal programmable divider of the system clock. The second is an external clock pin that runs at sixteen times the bit rate, which the block synchronizes and edge-detects. When the internal source is in use, its sixteen-times clock is driven out on the clock pin, and the output enable is raised.

Software-style control inputs set the behaviour. One input enables transmission; dropping it abandons the current frame at once and returns the line to the idle high level. A second input empties the queue, and a third selects the clock source. A transmission-end flag shows when everything queued has left the line.

Top module: `sertx_top`

## Requirements
- R1: After reset the serial line is high, the end flag is 1, the queue is empty (`fifo_empty`=1, `fifo_count`=0) and `fifo_full` is 0.
- R2: A frame is one low start bit, eight data bits with bit 0 first, and one high stop bit, each 16 ticks long. Bytes leave in write order, and a queued byte starts in the tick right after the previous stop bit ends.
- R3: With `ext_clk_sel`=0 a tick occurs every `baud_div`+1 system clocks, `sck_oe` is 1, and `sck_out` is a square wave with that same period.
- R4: With `ext_clk_sel`=1 each rising edge of `sck_in` makes one tick, `sck_oe` is 0 and `sck_out` is held low.
- R5: The queue holds 16 bytes, and `fifo_count` gives the number held. A write while `fifo_full`=1 is ignored: the count does not change and that byte is never sent.
- R6: Bytes written while `tx_en`=0 are stored but not sent, and the line stays high.
- R7: When `tx_en` is 0 at a clock edge, the line is high from that edge on and the frame in progress is dropped. After re-enable, the next byte goes out as a complete, correct frame.
- R8: Clearing `tx_en` does not change `tx_end` or the queued bytes.
- R9: `tx_end` goes to 1 when a stop bit completes and the queue is empty.
- R10: A write accepted while `tx_en`=1 clears `tx_end` at the next clock edge.
- R11: `fifo_clr` empties the queue at the next edge and takes priority over a write in the same cycle. A queue cleared this way sends nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| tx_en | input | 1 | Transmit enable |
| fifo_clr | input | 1 | Empty the transmit queue |
| ext_clk_sel | input | 1 | 1 = external 16x clock, 0 = internal divider |
| baud_div | input | DIV_W (12) | Internal divider: tick period is baud_div+1 clocks |
| wr_valid | input | 1 | Write strobe for the queue |
| wr_data | input | DATA_W (8) | Byte to queue |
| sck_in | input | 1 | External 16x clock |
| sck_out | output | 1 | Internal 16x clock output |
| sck_oe | output | 1 | Output enable for the clock pin |
| txd | output | 1 | Serial data line |
| tx_end | output | 1 | All queued data has been sent |
| fifo_full | output | 1 | Queue full |
| fifo_empty | output | 1 | Queue empty |
| fifo_count | output | CNT_W (5) | Bytes held in the queue |

## Verification
A wrong bit counter or tick divider shows up in the first frame after it goes wrong. The decoded byte, start bit or stop bit then mismatches within one frame time (160 ticks). A queue pointer fault reorders or drops bytes, which the scoreboard sees in the next frame it decodes; a count fault shows on `fifo_count` in the very next cycle. A shift register left dirty after an abort corrupts the first frame after re-enable. An end flag that is wrongly held or wrongly set is seen one cycle after a write, or at the end of the last stop bit.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

   // Shifter sequencing state
   typedef enum logic [0:0] {
      SH_IDLE = 1'b0,
      SH_BUSY = 1'b1
   } sh_state_e;

   // Number of bit slots in one frame: start + data + stop
   function automatic int unsigned frame_slots(input int unsigned data_w);
      return data_w + 2;
   endfunction

endpackage

// File: rtl/sertx_tick.sv
module sertx_tick #(
   parameter int unsigned DIV_W       = 12,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          HAS_EXT     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_sel,
   input  logic [DIV_W-1:0] div,
   input  logic             sck_in,
   output logic             tick,
   output logic             sck_out,
   output logic             sck_oe
);

   // internal divider
   logic [DIV_W-1:0] cnt_q;
   logic             int_tick;
   logic [DIV_W:0]   half_w;
   logic             sck_q;

   assign int_tick = (cnt_q >= div);
   assign half_w   = ({1'b0, div} + {{DIV_W{1'b0}}, 1'b1}) >> 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         sck_q <= 1'b0;
      end else begin
         if (int_tick) cnt_q <= '0;
         else          cnt_q <= cnt_q + 1'b1;
         sck_q <= ({1'b0, cnt_q} < half_w);
      end
   end

   generate
      if (HAS_EXT) begin : g_ext
         logic [SYNC_STAGES-1:0] sync_q;
         logic                   prev_q;
         logic                   ext_tick;

         for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[s] <= 1'b0;
               else if (s == 0) sync_q[s] <= sck_in;
               else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= sync_q[SYNC_STAGES-1];
         end

         assign ext_tick = sync_q[SYNC_STAGES-1] & ~prev_q;
         assign tick     = ext_sel ? ext_tick : int_tick;
         assign sck_out  = ext_sel ? 1'b0 : sck_q;
         assign sck_oe   = ~ext_sel;
      end else begin : g_int_only
         logic unused_w;
         assign unused_w = ext_sel ^ sck_in;
         assign tick     = int_tick;
         assign sck_out  = sck_q;
         assign sck_oe   = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clr,
   input  logic                         wr_en,
   input  logic [W-1:0]                 wr_data,
   input  logic                         rd_en,
   output logic [W-1:0]                 rd_data,
   output logic                         full,
   output logic                         empty,
   output logic [$clog2(DEPTH+1)-1:0]   count
);

   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned CW = $clog2(DEPTH+1);

   logic [W-1:0]  mem_q [DEPTH];
   logic [AW-1:0] wr_ptr_q, rd_ptr_q;
   logic [CW-1:0] cnt_q;
   logic          push, pop;

   assign full    = (cnt_q == CW'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign push    = wr_en && !full && !clr;
   assign pop     = rd_en && !empty && !clr;
   assign rd_data = mem_q[rd_ptr_q];
   assign count   = cnt_q;

   always_ff @(posedge clk) begin
      if (push) mem_q[wr_ptr_q] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         cnt_q    <= '0;
      end else if (clr) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         cnt_q    <= '0;
      end else begin
         if (push) wr_ptr_q <= wr_ptr_q + 1'b1;
         if (pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
   import sertx_pkg::*;
#(
   parameter int unsigned W   = 8,
   parameter int unsigned OVS = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tx_en,
   input  logic         tick,
   input  logic         fifo_empty,
   input  logic [W-1:0] fifo_data,
   output logic         pop,
   output logic         txd,
   output logic         frame_done
);

   localparam int unsigned SLOTS    = frame_slots(W);
   localparam int unsigned IDX_W    = $clog2(SLOTS);
   localparam int unsigned SUB_W    = $clog2(OVS);
   localparam int unsigned STOP_IDX = SLOTS - 1;

   sh_state_e        state_q;
   logic [W-1:0]     shreg_q;
   logic [IDX_W-1:0] idx_q;
   logic [SUB_W-1:0] sub_q;
   logic             txd_q;
   logic             slot_end, last_tick, launch;

   assign slot_end   = (state_q == SH_BUSY) && tick && (sub_q == SUB_W'(OVS-1));
   assign last_tick  = slot_end && (idx_q == IDX_W'(STOP_IDX));
   assign launch     = tx_en && tick && !fifo_empty &&
                       ((state_q == SH_IDLE) || last_tick);
   assign pop        = launch;
   assign frame_done = tx_en && last_tick;
   assign txd        = txd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SH_IDLE;
         shreg_q <= '0;
         idx_q   <= '0;
         sub_q   <= '0;
         txd_q   <= 1'b1;
      end else if (!tx_en) begin
         state_q <= SH_IDLE;
         shreg_q <= '0;
         idx_q   <= '0;
         sub_q   <= '0;
         txd_q   <= 1'b1;
      end else if (launch) begin
         state_q <= SH_BUSY;
         shreg_q <= fifo_data;
         idx_q   <= '0;
         sub_q   <= '0;
         txd_q   <= 1'b0;
      end else if ((state_q == SH_BUSY) && tick) begin
         if (slot_end) begin
            sub_q <= '0;
            if (last_tick) begin
               state_q <= SH_IDLE;
               idx_q   <= '0;
               txd_q   <= 1'b1;
            end else begin
               idx_q <= idx_q + 1'b1;
               if (idx_q == IDX_W'(W)) begin
                  txd_q <= 1'b1;
               end else begin
                  txd_q   <= shreg_q[0];
                  shreg_q <= shreg_q >> 1;
               end
            end
         end else begin
            sub_q <= sub_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned DEPTH       = 16,
   parameter int unsigned DIV_W       = 12,
   parameter int unsigned OVS         = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          HAS_EXT     = 1'b1,
   localparam int unsigned CNT_W      = $clog2(DEPTH+1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              fifo_clr,
   input  logic              ext_clk_sel,
   input  logic [DIV_W-1:0]  baud_div,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              sck_in,
   output logic              sck_out,
   output logic              sck_oe,
   output logic              txd,
   output logic              tx_end,
   output logic              fifo_full,
   output logic              fifo_empty,
   output logic [CNT_W-1:0]  fifo_count
);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH-1)) != 0) begin : g_bad_depth
         $error("sertx_top: DEPTH must be a power of two of at least 2");
      end
      if (OVS < 2 || (OVS & (OVS-1)) != 0) begin : g_bad_ovs
         $error("sertx_top: OVS must be a power of two of at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("sertx_top: SYNC_STAGES must be at least 2");
      end
      if (DATA_W < 1 || DIV_W < 1) begin : g_bad_width
         $error("sertx_top: DATA_W and DIV_W must be positive");
      end
   endgenerate

   logic              tick;
   logic              pop;
   logic              frame_done;
   logic [DATA_W-1:0] head_data;
   logic              wr_accept;
   logic              end_q;

   sertx_tick #(
      .DIV_W       (DIV_W),
      .SYNC_STAGES (SYNC_STAGES),
      .HAS_EXT     (HAS_EXT)
   ) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .ext_sel (ext_clk_sel),
      .div     (baud_div),
      .sck_in  (sck_in),
      .tick    (tick),
      .sck_out (sck_out),
      .sck_oe  (sck_oe)
   );

   sertx_fifo #(
      .W     (DATA_W),
      .DEPTH (DEPTH)
   ) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (fifo_clr),
      .wr_en   (wr_valid),
      .wr_data (wr_data),
      .rd_en   (pop),
      .rd_data (head_data),
      .full    (fifo_full),
      .empty   (fifo_empty),
      .count   (fifo_count)
   );

   sertx_shifter #(
      .W   (DATA_W),
      .OVS (OVS)
   ) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .tx_en      (tx_en),
      .tick       (tick),
      .fifo_empty (fifo_empty),
      .fifo_data  (head_data),
      .pop        (pop),
      .txd        (txd),
      .frame_done (frame_done)
   );

   // end flag: a write accepted while enabled wins over a completion
   assign wr_accept = wr_valid && tx_en && !fifo_full && !fifo_clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       end_q <= 1'b1;
      else if (wr_accept)               end_q <= 1'b0;
      else if (frame_done && !pop)      end_q <= 1'b1;
   end

   assign tx_end = end_q;

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tx_en,
   input logic             fifo_clr,
   input logic             wr_valid,
   input logic             fifo_full,
   input logic [CNT_W-1:0] fifo_count,
   input logic             txd,
   input logic             tx_end
);

   // R5
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_count <= CNT_W'(DEPTH));

   // R5
   full_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_full && wr_valid && !fifo_clr) |=> (fifo_count <= $past(fifo_count)));

   // R11
   fifo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_clr |=> (fifo_count == '0));

   // R7
   mark_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> txd);

   // R8
   end_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> (tx_end == $past(tx_end)));

   // R10
   end_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && tx_en && !fifo_full && !fifo_clr) |=> !tx_end);

endmodule

bind sertx_top sertx_chk #(
   .DEPTH (DEPTH),
   .CNT_W (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tx_en      (tx_en),
   .fifo_clr   (fifo_clr),
   .wr_valid   (wr_valid),
   .fifo_full  (fifo_full),
   .fifo_count (fifo_count),
   .txd        (txd),
   .tx_end     (tx_end)
);

// File: tb/sertx_top_tb.sv
module sertx_top_tb;

   localparam int DIV = 3;            // tick every 4 clocks

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tx_en = 1'b0;
   logic        fifo_clr = 1'b0;
   logic        ext_clk_sel = 1'b0;
   logic [11:0] baud_div = 12'(DIV);
   logic        wr_valid = 1'b0;
   logic [7:0]  wr_data = '0;
   logic        sck_in = 1'b0;
   logic        sck_out, sck_oe, txd, tx_end, fifo_full, fifo_empty;
   logic [4:0]  fifo_count;

   int checks = 0;
   int errors = 0;
   logic [7:0] exp_q[$];
   int  bit_clks = 64;
   bit  skip_frame = 1'b0;
   bit  ext_run = 1'b0;
   bit  done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   sertx_top u_dut (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .fifo_clr(fifo_clr),
      .ext_clk_sel(ext_clk_sel), .baud_div(baud_div), .wr_valid(wr_valid),
      .wr_data(wr_data), .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
      .txd(txd), .tx_end(tx_end), .fifo_full(fifo_full),
      .fifo_empty(fifo_empty), .fifo_count(fifo_count)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic put(input logic [7:0] b, input bit track);
      @(negedge clk);
      if (!fifo_full && track) exp_q.push_back(b);
      wr_valid = 1'b1;
      wr_data  = b;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic wait_clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   // external 16x clock: period 8 system clocks
   initial begin
      forever begin
         repeat (4) @(negedge clk);
         if (ext_run) sck_in = ~sck_in;
      end
   end

   // monitor / scoreboard
   initial begin
      logic [7:0] rx;
      logic       st_ok, sp_ok;
      logic [7:0] e;
      int         bc;
      forever begin
         @(negedge clk);
         if (rst_n && txd === 1'b0) begin
            bc = bit_clks;
            repeat (bc/2) @(negedge clk);
            st_ok = (txd === 1'b0);
            for (int i = 0; i < 8; i++) begin
               repeat (bc) @(negedge clk);
               rx[i] = txd;
            end
            repeat (bc) @(negedge clk);
            sp_ok = (txd === 1'b1);
            if (skip_frame) begin
               if (exp_q.size() != 0) void'(exp_q.pop_front());
               skip_frame = 1'b0;
            end else if (exp_q.size() == 0) begin
               check(1'b0, "R2 unexpected frame", int'(rx), -1);
            end else begin
               e = exp_q.pop_front();
               // R2: start low, LSB first, stop high, write order
               check(st_ok && sp_ok && rx == e, "R2 frame byte", int'(rx), int'(e));
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int edges;
      logic prev;
      bit line_hi;
      wait_clks(5);
      rst_n = 1'b1;
      wait_clks(2);

      // R1 reset state
      check(txd === 1'b1, "R1 txd", int'(txd), 1);
      check(tx_end === 1'b1, "R1 tx_end", int'(tx_end), 1);
      check(fifo_empty === 1'b1 && fifo_count == 0 && fifo_full === 1'b0,
            "R1 fifo", int'(fifo_count), 0);

      // R3 internal clock out
      check(sck_oe === 1'b1, "R3 sck_oe", int'(sck_oe), 1);
      edges = 0; prev = sck_out;
      for (int k = 0; k < 400; k++) begin
         @(negedge clk);
         if (sck_out && !prev) edges++;
         prev = sck_out;
      end
      check(edges >= 99 && edges <= 101, "R3 sck_out edges", edges, 100);

      // R5/R6: fill while disabled, two extra writes ignored
      for (int k = 0; k < 18; k++) put(8'(8'h11 * k + 3), 1'b1);
      check(fifo_count == 16, "R5 count", int'(fifo_count), 16);
      check(fifo_full === 1'b1, "R5 full", int'(fifo_full), 1);
      line_hi = 1'b1;
      for (int k = 0; k < 200; k++) begin
         @(negedge clk);
         if (txd !== 1'b1) line_hi = 1'b0;
      end
      check(line_hi, "R6 line idle while disabled", int'(line_hi), 1);
      check(fifo_count == 16, "R6 bytes kept", int'(fifo_count), 16);

      // R2/R5: enable and drain 16 frames back to back
      tx_en = 1'b1;
      while (exp_q.size() != 0) @(negedge clk);
      wait_clks(1000);
      check(fifo_count == 0 && txd === 1'b1, "R5 no extra byte", int'(fifo_count), 0);

      // R11: clear discards queued bytes
      tx_en = 1'b0;
      for (int k = 0; k < 4; k++) put(8'hC0 + 8'(k), 1'b0);
      check(fifo_count == 4, "R11 pre-clear count", int'(fifo_count), 4);
      @(negedge clk);
      fifo_clr = 1'b1;
      wr_valid = 1'b1;
      wr_data  = 8'hEE;
      @(negedge clk);
      fifo_clr = 1'b0;
      wr_valid = 1'b0;
      check(fifo_count == 0 && fifo_empty === 1'b1, "R11 cleared", int'(fifo_count), 0);
      tx_en = 1'b1;
      wait_clks(1000);
      check(txd === 1'b1 && fifo_count == 0, "R11 nothing sent", int'(txd), 1);

      // R10 / R9
      put(8'h3C, 1'b1);
      check(tx_end === 1'b0, "R10 tx_end cleared", int'(tx_end), 0);
      while (tx_end !== 1'b1) @(negedge clk);
      check(exp_q.size() == 0 && fifo_count == 0, "R9 tx_end after last stop",
            exp_q.size(), 0);

      // R7 / R8: abort mid-frame
      skip_frame = 1'b1;
      put(8'h00, 1'b1);
      put(8'hA5, 1'b1);
      wait_clks(200);
      tx_en = 1'b0;
      wait_clks(1);
      check(txd === 1'b1, "R7 mark after disable", int'(txd), 1);
      check(tx_end === 1'b0, "R8 tx_end held", int'(tx_end), 0);
      check(fifo_count == 1, "R8 queue kept", int'(fifo_count), 1);
      wait_clks(700);
      tx_en = 1'b1;
      while (tx_end !== 1'b1) @(negedge clk);
      check(exp_q.size() == 0, "R7 clean frame after re-enable", exp_q.size(), 0);

      // R4: external clock
      ext_run = 1'b1;
      ext_clk_sel = 1'b1;
      bit_clks = 128;
      wait_clks(2);
      check(sck_oe === 1'b0 && sck_out === 1'b0, "R4 clock pin released",
            int'(sck_oe), 0);
      put(8'h81, 1'b1);
      put(8'h5A, 1'b1);
      while (exp_q.size() != 0) @(negedge clk);
      while (tx_end !== 1'b1) @(negedge clk);
      check(fifo_count == 0 && txd === 1'b1, "R4 external frames done",
            int'(fifo_count), 0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule